// File: doc/BRIEF.md
# Configurable Serial Transmit Channel

This block is the transmit half of an asynchronous serial port. Software writes a byte into a one-entry holding buffer. When the shift engine is free, and transmission is enabled, the byte moves at once into the shift engine. The shift engine then sends a frame on `txd`. The line idles high. A frame is a low start bit, then the data least significant bit first, then an optional parity bit, then one or two high stop bits. The data length, parity use and sense, and stop count come from static configuration inputs. They are captured when a byte enters the shift engine, so one frame never mixes two settings.

Each serial bit lasts sixteen timing events. A timing event is either a tick from an external bit-rate generator or a rising edge of an external clock pin, which is synchronised into the block clock first. Two status outputs are provided. `buf_empty` reports that the holding buffer is free. `shift_done` reports that the line has finished its last frame. A single-cycle interrupt pulse follows one of these two events, chosen by a configuration bit.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1, `shift_done` is 1 and `tx_irq` is 0; `txd` is 1 whenever no frame is in progress.
- R2: A frame starts with one 0 bit, followed by data bits least significant first: 8 bits when `cfg_len7`=0, bits 0..6 only when `cfg_len7`=1.
- R3: With `cfg_par_en`=1 one parity bit follows the data; `cfg_par_odd`=0 makes the count of ones over sent data plus parity even, 1 makes it odd. With `cfg_par_en`=0 no parity bit is sent.
- R4: The frame ends with one stop bit of 1 when `cfg_stop2`=0 and two when `cfg_stop2`=1, after which the line stays 1.
- R5: `buf_empty` reads 0 in the cycle after a write. It returns to 1 on the same clock edge that moves the byte into the shift engine. When the engine is idle and transmission is enabled, that edge is the one right after the write.
- R6: `shift_done` falls on the edge that starts a frame and rises only when the last stop bit ends with no byte pending. Back-to-back frames leave no idle gap and keep `shift_done` at 0.
- R7: `tx_irq` is a one-cycle pulse. With `cfg_irq_on_done`=0 it is high in the cycle `buf_empty` returns to 1 (while `shift_done` is 0). With `cfg_irq_on_done`=1 it is high in the first cycle `shift_done` reads 1 after a frame.
- R8: Every bit lasts 16 `brg_tick` pulses when `cfg_ext_clk`=0. When `cfg_ext_clk`=1 it lasts 16 rising edges of `ext_clk`, and `brg_tick` is ignored.
- R9: While `tx_enable`=0 no byte enters the shift engine: `txd` stays 1, `buf_empty` stays 0 and `shift_done` stays 1. Setting `tx_enable` starts the pending byte on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| tx_enable | input | 1 | Allows bytes to enter the shift engine |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_irq_on_done | input | 1 | Interrupt source: 0 buffer emptied, 1 shifting finished |
| cfg_ext_clk | input | 1 | 1 times bits from `ext_clk` instead of `brg_tick` |
| brg_tick | input | 1 | One-cycle tick from the bit-rate generator |
| ext_clk | input | 1 | External timing clock, asynchronous |
| txd | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Holding buffer is free |
| shift_done | output | 1 | No frame is being shifted |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
Frames are sent with the data values 0xA5, 0xD3, 0x00, 0x3C and the pair 0x12/0x34. Each is paired with a different setting of length, parity and stop count. This shows whether bit 7 is dropped in 7-bit mode, whether the parity sense is right (the all-zero byte with odd parity needs a 1), and whether the second stop bit is held for its full time. The same byte path is run once from generator ticks and once from a slower external clock while ticks keep arriving, so a block that counts the wrong timing source gives the wrong bit length. The remaining runs use a held-off enable and a second write made during a frame. These show whether the buffer-empty and shift-complete flags and the two interrupt sources are kept apart.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned FRAME_MAX = 12;
  localparam int unsigned LEN_W     = 4;

  // Frame image, bit 0 leaves first; unused upper positions stay at 1.
  function automatic logic [FRAME_MAX-1:0] build_frame(
      input logic [DATA_W-1:0] d, input logic len7,
      input logic par_en, input logic par_odd);
    logic [FRAME_MAX-1:0] f;
    logic [LEN_W-1:0]     pos;
    logic                 p;
    f    = '1;
    f[0] = 1'b0;
    pos  = LEN_W'(1);
    p    = par_odd;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (!(len7 && i == int'(DATA_W) - 1)) begin
        f[pos] = d[i];
        p      = p ^ d[i];
        pos    = pos + LEN_W'(1);
      end
    end
    if (par_en) f[pos] = p;
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(
      input logic len7, input logic par_en, input logic stop2);
    return LEN_W'(DATA_W + 2) - LEN_W'(len7) + LEN_W'(par_en) + LEN_W'(stop2);
  endfunction
endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
  parameter int unsigned OVS    = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brg_tick,
  input  logic ext_clk,
  input  logic ext_sel,
  input  logic restart,
  output logic bit_end
);
  localparam int unsigned CNT_W = $clog2(OVS);

  logic [SYNC_N:0]  ext_q;
  logic             ext_rise;
  logic             src_tick;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= {ext_q[SYNC_N-1:0], ext_clk};
  end

  assign ext_rise = ext_q[SYNC_N-1] & ~ext_q[SYNC_N];
  assign src_tick = ext_sel ? ext_rise : brg_tick;
  assign bit_end  = src_tick && (cnt == CNT_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (src_tick) cnt <= bit_end ? '0 : cnt + CNT_W'(1);
  end

  // R8: a bit can only end on a timing event of the selected source
  p_end_on_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> (ext_sel ? (ext_q[SYNC_N-1] && !ext_q[SYNC_N]) : brg_tick));
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr_en) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R5: the shift engine only takes a byte that is actually held
  p_take_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] frame_in,
  input  logic [LEN_W-1:0]     len_in,
  input  logic                 bit_end,
  output logic                 busy,
  output logic                 last_end,
  output logic                 txd
);
  logic [FRAME_MAX-1:0] sreg;
  logic [LEN_W-1:0]     idx;
  logic [LEN_W-1:0]     len_q;

  assign last_end = busy && bit_end && (idx == len_q - LEN_W'(1));
  assign txd      = busy ? sreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '1;
      idx   <= '0;
      len_q <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      sreg  <= frame_in;
      idx   <= '0;
      len_q <= len_in;
      busy  <= 1'b1;
    end else if (busy && bit_end) begin
      if (last_end) begin
        busy <= 1'b0;
      end else begin
        sreg <= {1'b1, sreg[FRAME_MAX-1:1]};
        idx  <= idx + LEN_W'(1);
      end
    end
  end

  // R1: line is high whenever no frame is in progress
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R2: a loaded frame begins with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
  import uart_tx_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              cfg_len7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              cfg_irq_on_done,
  input  logic              cfg_ext_clk,
  input  logic              brg_tick,
  input  logic              ext_clk,
  output logic              txd,
  output logic              buf_empty,
  output logic              shift_done,
  output logic              tx_irq
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              last_end;
  logic              bit_end;
  logic              load_evt;
  logic              done_evt;
  logic              done_q;
  logic              irq_q;

  // Named internal events
  assign load_evt = hold_full && tx_enable && (!busy || last_end);
  assign done_evt = last_end && !load_evt;

  uart_tx_hold #(.W(DATA_W)) u_hold (
    .clk, .rst_n, .wr_en, .wr_data,
    .take (load_evt),
    .full (hold_full),
    .data (hold_data)
  );

  uart_tx_tick #(.OVS(OVS), .SYNC_N(SYNC_N)) u_tick (
    .clk, .rst_n, .brg_tick, .ext_clk,
    .ext_sel (cfg_ext_clk),
    .restart (load_evt),
    .bit_end (bit_end)
  );

  uart_tx_shift u_shift (
    .clk, .rst_n,
    .load     (load_evt),
    .frame_in (build_frame(hold_data, cfg_len7, cfg_par_en, cfg_par_odd)),
    .len_in   (frame_len(cfg_len7, cfg_par_en, cfg_stop2)),
    .bit_end  (bit_end),
    .busy     (busy),
    .last_end (last_end),
    .txd      (txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      if (load_evt)      done_q <= 1'b0;
      else if (done_evt) done_q <= 1'b1;
      irq_q <= cfg_irq_on_done ? done_evt : load_evt;
    end
  end

  assign buf_empty  = !hold_full;
  assign shift_done = done_q;
  assign tx_irq     = irq_q;

  // R5: moving the byte frees the buffer unless a new write lands on that edge
  p_empty_after_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_en) |=> buf_empty);
  // R6: starting a frame clears the completion flag
  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !shift_done);
  // R6: completion only rises at the end of a final stop bit
  p_done_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_done) |-> $past(last_end));
  // R7: interrupt is a single-cycle pulse
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
  // R9: no byte enters the shift engine while transmission is disabled
  p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> tx_enable);
endmodule

// File: tb/uart_tx_chan_test.sv
module uart_tx_chan_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_enable = 1'b1;
  logic       cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_stop2 = 1'b0, cfg_irq_on_done = 1'b0, cfg_ext_clk = 1'b0;
  logic       brg_tick = 1'b0, ext_clk = 1'b0;
  logic       txd, buf_empty, shift_done, tx_irq;

  int n_chk = 0, n_bad = 0;
  int irq_cnt = 0;
  logic irq_done_at = 1'b0, irq_empty_at = 1'b0;
  int bcnt = 0, ecnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_tx_chan uut (.*);

  // tick every 4 clocks; external clock period 8 clocks
  always @(negedge clk) begin
    bcnt = (bcnt + 1) % 4;
    brg_tick = (bcnt == 0);
    ecnt = (ecnt + 1) % 4;
    if (ecnt == 0) ext_clk = ~ext_clk;
  end

  always @(negedge clk) if (rst_n && tx_irq) begin
    irq_cnt++;
    irq_done_at  = shift_done;
    irq_empty_at = buf_empty;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len();
    return 10 - int'(cfg_len7) + int'(cfg_par_en) + int'(cfg_stop2);
  endfunction

  function automatic logic [23:0] exp_frame(input logic [7:0] d);
    logic [23:0] v;
    logic [7:0]  m;
    int nd;
    nd = cfg_len7 ? 7 : 8;
    m  = cfg_len7 ? 8'h7F : 8'hFF;
    v  = '1;
    v[0] = 1'b0;
    for (int i = 0; i < nd; i++) v[1 + i] = d[i];
    if (cfg_par_en) v[1 + nd] = cfg_par_odd ^ (^(d & m));
    return v;
  endfunction

  // Called at the first negedge after the load edge.
  task automatic capture(input string req, input logic [23:0] e, input int n,
                         input int step, input int irq0);
    int x;
    repeat (step / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk(txd == e[i], req, $sformatf("bit %0d", i), txd, e[i]);
      if (i == n - 1) chk(shift_done == 1'b0, "R6", "busy in last bit", shift_done, 0);
      if (i < n - 1) repeat (step) @(negedge clk);
    end
    x = 0;
    while (!shift_done && x < 4 * step) begin
      @(negedge clk);
      x++;
    end
    chk(x >= step / 2 - step / 16 - 2 && x <= step / 2 + 2, "R8",
        "cycles from last mid-bit to completion", x, step / 2);
    repeat (step) @(negedge clk);
    chk(txd == 1'b1, "R4", "line high after stop", txd, 1);
    chk(irq_cnt == irq0 + 1, "R7", "interrupt pulses", irq_cnt - irq0, 1);
    chk(irq_done_at == cfg_irq_on_done, "R7", "shift_done at pulse",
        irq_done_at, cfg_irq_on_done);
  endtask

  task automatic send(input string req, input logic [7:0] d, input int step);
    int irq0;
    irq0 = irq_cnt;
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    chk(buf_empty == 1'b0, "R5", "buffer full after write", buf_empty, 0);
    @(negedge clk);
    chk(buf_empty == 1'b1, "R5", "buffer empty after move", buf_empty, 1);
    chk(shift_done == 1'b0, "R6", "shift_done falls at start", shift_done, 1'b0);
    if (!cfg_irq_on_done)
      chk(tx_irq == 1'b1, "R7", "pulse with buffer empty", tx_irq, 1);
    capture(req, exp_frame(d), exp_len(), step, irq0);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R1", "txd idle", txd, 1);
    chk(buf_empty == 1'b1, "R1", "buf_empty", buf_empty, 1);
    chk(shift_done == 1'b1, "R1", "shift_done", shift_done, 1);
    chk(tx_irq == 1'b0, "R1", "tx_irq", tx_irq, 0);
  endtask

  task automatic t_basic_8n1();
    cfg_len7 = 0; cfg_par_en = 0; cfg_stop2 = 0; cfg_irq_on_done = 0; cfg_ext_clk = 0;
    send("R2", 8'hA5, 64);
  endtask

  task automatic t_7bit_even_2stop();
    cfg_len7 = 1; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 1; cfg_irq_on_done = 1;
    send("R3", 8'hD3, 64);
  endtask

  task automatic t_odd_parity_zero();
    cfg_len7 = 0; cfg_par_en = 1; cfg_par_odd = 1; cfg_stop2 = 0; cfg_irq_on_done = 0;
    send("R3", 8'h00, 64);
  endtask

  task automatic t_ext_clock();
    cfg_len7 = 0; cfg_par_en = 0; cfg_stop2 = 1; cfg_irq_on_done = 1; cfg_ext_clk = 1;
    send("R8", 8'h3C, 128);
    cfg_ext_clk = 0;
  endtask

  task automatic t_tx_disabled();
    int lows, irq0;
    cfg_len7 = 0; cfg_par_en = 0; cfg_stop2 = 0; cfg_irq_on_done = 0;
    irq0 = irq_cnt;
    tx_enable = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h81;
    @(negedge clk); wr_en = 1'b0;
    lows = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk(lows == 0, "R9", "line low cycles while disabled", lows, 0);
    chk(buf_empty == 1'b0, "R9", "byte still pending", buf_empty, 0);
    chk(shift_done == 1'b1, "R9", "shift_done while disabled", shift_done, 1);
    chk(irq_cnt == irq0, "R9", "no interrupt while disabled", irq_cnt - irq0, 0);
    tx_enable = 1'b1;
    @(negedge clk);
    chk(buf_empty == 1'b1 && txd == 1'b0, "R9", "start after enable",
        {buf_empty, txd}, 2);
    capture("R9", exp_frame(8'h81), exp_len(), 64, irq0);
  endtask

  task automatic t_back_to_back();
    logic [23:0] ea, eb, e;
    int na, irq0;
    cfg_len7 = 0; cfg_par_en = 0; cfg_stop2 = 0; cfg_irq_on_done = 1;
    irq0 = irq_cnt;
    ea = exp_frame(8'h12); eb = exp_frame(8'h34); na = exp_len();
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h12;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    chk(buf_empty == 1'b1, "R5", "first byte moved", buf_empty, 1);
    wr_en = 1'b1; wr_data = 8'h34;
    @(negedge clk); wr_en = 1'b0;
    chk(buf_empty == 1'b0, "R5", "second byte pending during frame", buf_empty, 0);
    e = ea;
    for (int i = 0; i < na; i++) e[na + i] = eb[i];
    capture("R6", e, 2 * na, 64, irq0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic_8n1();
    t_7bit_even_2stop();
    t_odd_parity_zero();
    t_ext_clock();
    t_tx_disabled();
    t_back_to_back();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule